// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block keeps a 17-bit word of pending software interrupts together with a 4-bit processor interrupt level. It drives one registered request line per pending bit. A request is raised only when the interrupt level allows that bit through. Software reaches the block through a small write port with four selectable targets:
- the pending word itself, replaced whole;
- an OR-in alias that sets bits;
- an AND-NOT alias that clears bits;
- the level register.

Timer compare logic outside the block signals matches on two pulse inputs. A tick match sets bit 0 and a system-tick match sets bit 16. Both go through the same OR path that the set alias uses.

Bits 0 and 16 are timer bits. They share one fixed threshold: each requests only while the level is below 14. Each middle bit n (1 to 15) requests only when n is strictly above the level. A write to any target updates the stored state and the request lines on the same clock edge. No other write is needed to recompute them.

Top module: `softint_irq_top`

## Requirements
- R1: After reset the pending word and the level are zero, all request lines are low, and reads of every target return zero.
- R2: A write with select 0 replaces the pending word with the written data. Reads with select 0, 1 or 2 return the pending word as it stands.
- R3: A write with select 1 stores the old pending word ORed with the written data.
- R4: A write with select 2 stores the old pending word ANDed with the inverse of the written data.
- R5: A write with select 3 stores data bits 3:0 as the level and ignores the data bits above them. A read with select 3 returns the level zero-extended to 17 bits.
- R6: Request lines 0 and 16 are high exactly when their pending bit is set and the level is below 14.
- R7: For n from 1 to 15, request line n is high exactly when pending bit n is set and n is strictly greater than the level. At level 15 none of lines 1 to 15 can be high.
- R8: The request lines are registered. After every clock edge they match the rule of R6 and R7 applied to the pending word and level stored at that edge, so a write to any target is reflected on the same edge that stores it.
- R9: A high tickMatch sets pending bit 0 and a high stickMatch sets pending bit 16. The set is ORed in after any software write of the same cycle, so it wins over a same-cycle clear or a direct write of zero.
- R10: With wrEn low and both match inputs low, the pending word and the level keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the selected target |
| regSel | input | 2 | Target: 0 direct, 1 set alias, 2 clear alias, 3 level |
| wrData | input | 17 | Write data |
| tickMatch | input | 1 | Tick compare match pulse, sets bit 0 |
| stickMatch | input | 1 | System-tick compare match pulse, sets bit 16 |
| rdData | output | 17 | Combinational read of the selected target |
| irqReq | output | 17 | Registered interrupt request lines |

## Verification
The assertions assume that rstN is held low for at least one clock edge before any check matters. They also assume that regSel and wrData are stable and defined whenever wrEn is high. The match inputs may arrive in any cycle, including a cycle with a software write.

The stimulus changes every input only at the falling edge. Between random writes it keeps the reset low for several cycles at the start. It biases level writes toward the boundary values 13, 14 and 15, and it sends match pulses often enough that many of them coincide with clear writes and direct writes.

// File: rtl/softint_pkg.sv
package softint_pkg;

  // write/read target select; the numeric codes are part of the port contract
  typedef enum logic [1:0] {
    SEL_DIRECT = 2'd0,
    SEL_SET    = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_LEVEL  = 2'd3
  } regSel_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic loadDirect;
    logic loadSet;
    logic loadClear;
    logic loadLevel;
  } strobe_t;

endpackage

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regSel,
  output strobe_t    strb
);

  regSel_e selDec;

  always_comb begin
    selDec = regSel_e'(regSel);
    strb   = '0;
    if (wrEn) begin
      unique case (selDec)
        SEL_DIRECT: strb.loadDirect = 1'b1;
        SEL_SET:    strb.loadSet    = 1'b1;
        SEL_CLEAR:  strb.loadClear  = 1'b1;
        SEL_LEVEL:  strb.loadLevel  = 1'b1;
        default:    strb            = '0;
      endcase
    end
  end

  // a write drives exactly one strobe, an idle cycle drives none (R2..R5, R10)
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $countones(strb) == 1);
  p_idle_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> strb == '0);

endmodule

// File: rtl/softint_dp.sv
module softint_dp
  import softint_pkg::*;
#(
  parameter int NUM_BITS = 17,
  parameter int PIL_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [NUM_BITS-1:0] wrData,
  input  logic [NUM_BITS-1:0] hwSet,
  input  logic [1:0]          rdSel,
  output logic [NUM_BITS-1:0] softQ,
  output logic [PIL_W-1:0]    pilQ,
  output logic [NUM_BITS-1:0] softNext,
  output logic [PIL_W-1:0]    pilNext,
  output logic [NUM_BITS-1:0] rdData
);

  localparam int PAD_W = NUM_BITS - PIL_W;

  logic [NUM_BITS-1:0] softSw;

  // software operation first, hardware set ORed in afterwards (R9)
  always_comb begin
    softSw = softQ;
    if (strb.loadDirect) softSw = wrData;
    if (strb.loadSet)    softSw = softQ | wrData;
    if (strb.loadClear)  softSw = softQ & ~wrData;
    softNext = softSw | hwSet;
    pilNext  = strb.loadLevel ? wrData[PIL_W-1:0] : pilQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softQ <= '0;
      pilQ  <= '0;
    end else begin
      softQ <= softNext;
      pilQ  <= pilNext;
    end
  end

  always_comb begin
    if (regSel_e'(rdSel) == SEL_LEVEL) rdData = {{PAD_W{1'b0}}, pilQ};
    else                               rdData = softQ;
  end

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSet |=> softQ == ($past(softQ) | $past(wrData) | $past(hwSet)));
  p_clear_alias_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadClear |=> softQ == (($past(softQ) & ~$past(wrData)) | $past(hwSet)));
  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    hwSet[NUM_BITS-1] |=> softQ[NUM_BITS-1]);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0 && hwSet == '0) |=> ($stable(softQ) && $stable(pilQ)));

endmodule

// File: rtl/softint_mask.sv
module softint_mask #(
  parameter int NUM_BITS      = 17,
  parameter int PIL_W         = 4,
  parameter int SPECIAL_LEVEL = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_BITS-1:0] softNext,
  input  logic [PIL_W-1:0]    pilNext,
  output logic [NUM_BITS-1:0] irqQ
);

  localparam int LAST = NUM_BITS - 1;
  localparam logic [PIL_W-1:0] SPECIAL_LVL = PIL_W'(SPECIAL_LEVEL);

  logic [NUM_BITS-1:0] reqNext;

  for (genvar n = 0; n < NUM_BITS; n++) begin : g_bit
    if (n == 0 || n == LAST) begin : g_timer
      // timer bits use the fixed threshold (R6)
      assign reqNext[n] = softNext[n] && (pilNext < SPECIAL_LVL);
    end else begin : g_level
      localparam logic [PIL_W:0] BIT_LVL = (PIL_W+1)'(n);
      // middle bits compare their own index to the level (R7)
      assign reqNext[n] = softNext[n] && ({1'b0, pilNext} < BIT_LVL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= '0;
    else       irqQ <= reqNext;
  end

endmodule

// File: rtl/softint_irq_top.sv
module softint_irq_top
  import softint_pkg::*;
#(
  parameter int NUM_BITS      = 17,
  parameter int PIL_W         = 4,
  parameter int SPECIAL_LEVEL = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          regSel,
  input  logic [NUM_BITS-1:0] wrData,
  input  logic                tickMatch,
  input  logic                stickMatch,
  output logic [NUM_BITS-1:0] rdData,
  output logic [NUM_BITS-1:0] irqReq
);

  localparam int LAST = NUM_BITS - 1;

  strobe_t             strb;
  logic [NUM_BITS-1:0] hwSet;
  logic [NUM_BITS-1:0] softQ;
  logic [NUM_BITS-1:0] softNext;
  logic [PIL_W-1:0]    pilQ;
  logic [PIL_W-1:0]    pilNext;

  always_comb begin
    hwSet       = '0;
    hwSet[0]    = tickMatch;
    hwSet[LAST] = stickMatch;
  end

  softint_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .regSel (regSel),
    .strb   (strb)
  );

  softint_dp #(.NUM_BITS(NUM_BITS), .PIL_W(PIL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .hwSet    (hwSet),
    .rdSel    (regSel),
    .softQ    (softQ),
    .pilQ     (pilQ),
    .softNext (softNext),
    .pilNext  (pilNext),
    .rdData   (rdData)
  );

  softint_mask #(.NUM_BITS(NUM_BITS), .PIL_W(PIL_W), .SPECIAL_LEVEL(SPECIAL_LEVEL)) u_mask (
    .clk      (clk),
    .rstN     (rstN),
    .softNext (softNext),
    .pilNext  (pilNext),
    .irqQ     (irqReq)
  );

  // requests stay a subset of the stored pending word (R8)
  p_req_subset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~softQ) == '0);
  p_timer_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq[0] || irqReq[LAST]) |-> (pilQ < PIL_W'(SPECIAL_LEVEL)));
  p_top_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pilQ == '1) |-> (irqReq[LAST-1:1] == '0));
  p_level_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLevel |=> pilQ == $past(wrData[PIL_W-1:0]));

endmodule

// File: tb/tb_softint_irq_top.sv
module tb_softint_irq_top;

  localparam int NB = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [NB-1:0] wrData = '0;
  logic          tickMatch = 1'b0;
  logic          stickMatch = 1'b0;
  logic [NB-1:0] rdData;
  logic [NB-1:0] irqReq;

  int errors = 0;
  int checks = 0;
  logic [NB-1:0] mSoft = '0;
  logic [3:0]    mPil = '0;

  always #2 clk = ~clk;

  softint_irq_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .tickMatch(tickMatch), .stickMatch(stickMatch), .rdData(rdData), .irqReq(irqReq)
  );

  function automatic logic [NB-1:0] expIrq(logic [NB-1:0] s, logic [3:0] p);
    logic [NB-1:0] r;
    r = '0;
    r[0]    = s[0] && (p < 4'd14);
    r[NB-1] = s[NB-1] && (p < 4'd14);
    for (int n = 1; n < NB-1; n++) r[n] = s[n] && (n > int'(p));
    return r;
  endfunction

  function automatic logic [NB-1:0] expRead(logic [1:0] sel);
    return (sel == 2'd3) ? {13'd0, mPil} : mSoft;
  endfunction

  task automatic check(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: check requests, drive inputs, check read, advance model
  task automatic step(string irqTag, string rdTag, logic we, logic [1:0] sel,
                      logic [NB-1:0] d, logic tk, logic st);
    @(negedge clk);
    check(irqTag, irqReq, expIrq(mSoft, mPil));
    wrEn = we; regSel = sel; wrData = d; tickMatch = tk; stickMatch = st;
    #1;
    check(rdTag, rdData, expRead(sel));
    if (we) begin
      case (sel)
        2'd0: mSoft = d;
        2'd1: mSoft = mSoft | d;
        2'd2: mSoft = mSoft & ~d;
        default: mPil = d[3:0];
      endcase
    end
    if (tk) mSoft[0] = 1'b1;
    if (st) mSoft[NB-1] = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [NB-1:0] d;
    logic [1:0] s;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 irq", irqReq, '0);
    regSel = 2'd0; #1; check("R1 read soft", rdData, '0);
    regSel = 2'd3; #1; check("R1 read level", rdData, '0);
    @(negedge clk); rstN = 1'b1;

    // R2 direct write and alias reads
    step("R1", "R2", 1, 2'd0, 17'h1_2345, 0, 0);
    step("R8", "R2", 0, 2'd1, '0, 0, 0);
    step("R8", "R2", 0, 2'd2, '0, 0, 0);
    // R3 set, R4 clear
    step("R8", "R3", 1, 2'd1, 17'h0_00f0, 0, 0);
    step("R8", "R4", 1, 2'd2, 17'h1_0005, 0, 0);
    step("R8", "R2", 0, 2'd0, '0, 0, 0);
    // R5 level with upper bits ignored
    step("R8", "R5", 1, 2'd3, 17'h1_fffd, 0, 0);
    step("R8", "R5", 0, 2'd3, '0, 0, 0);
    // R6 timer bits at levels 13 and 14
    step("R8", "R2", 1, 2'd0, 17'h1_ffff, 0, 0);
    step("R6", "R5", 0, 2'd3, '0, 0, 0);
    step("R6", "R5", 1, 2'd3, 17'd14, 0, 0);
    step("R6", "R5", 0, 2'd3, '0, 0, 0);
    // R7 level 15 masks all middle bits, level n vs n-1
    step("R7", "R5", 1, 2'd3, 17'd15, 0, 0);
    step("R7", "R5", 1, 2'd3, 17'd7, 0, 0);
    step("R7", "R2", 1, 2'd0, 17'h0_0080, 0, 0);
    step("R7", "R5", 1, 2'd3, 17'd6, 0, 0);
    step("R7", "R5", 0, 2'd3, '0, 0, 0);
    // R9 matches win over clear and direct zero
    step("R7", "R4", 1, 2'd2, 17'h1_ffff, 1, 1);
    step("R9", "R2", 1, 2'd0, 17'h0_0000, 0, 1);
    step("R9", "R2", 0, 2'd0, '0, 0, 0);
    // R10 idle hold
    step("R10", "R10", 0, 2'd0, 17'h0_ffff, 0, 0);
    step("R10", "R10", 0, 2'd3, 17'h0_ffff, 0, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      s = 2'($urandom % 4);
      d = NB'($urandom);
      if (s == 2'd3 && ($urandom % 2) == 0) d[3:0] = 4'(13 + $urandom % 3);
      step("R8", "R2", ($urandom % 4) != 0, s, d,
           ($urandom % 6) == 0, ($urandom % 6) == 0);
    end
    step("R8", "R5", 0, 2'd3, '0, 0, 0);
    finishRun();
  end

endmodule